// File: doc/BRIEF.md
# Factory Bad-Block Scanner

This engine runs once when the flash subsystem comes up. On a start pulse it probes every erase block of the attached NAND array in ascending order. For each block it hands the command sequencer one page-read request aimed at the first page of that block and at the first byte past the data area, then takes the single byte that comes back. That byte is the factory marker. A block whose marker says bad gets a bit in an on-chip bitmap, and a running tally counts it.

When the last block has been judged, the engine raises a done flag and goes quiet. Firmware can then query any block through a lookup port before it builds its allocation tables. Erase must never be sent to a flagged block, because erasing destroys the marker and it cannot be written back. The tally is compared against the lifetime allowance for bad blocks. Going past that allowance raises a sticky overflow flag, but the walk still finishes so that the bitmap is complete.

Two marker rules are available through a parameter. The lenient rule flags only a marker of 00h. The strict rule flags any marker other than FFh, which covers every 00h marker and more.

Top module: `badblk_scanner`

## Requirements
- R1: After reset, cmd_valid, busy, done and overflow are 0 and bad_count is 0.
- R2: For block b the request has cmd_row = b·PAGES_PER_BLOCK, which is page 0 of the block, and cmd_col = DATA_BYTES, the first spare byte. Blocks are requested one at a time in ascending order from 0 to NUM_BLOCKS-1. A request that is not yet accepted holds cmd_valid high and keeps its row unchanged.
- R3: Once a request is accepted (cmd_valid and cmd_ready both high at a clock edge), cmd_valid stays low until one rd_valid byte has arrived. An rd_valid pulse while a request is still pending is ignored.
- R4: With STRICT_MARK=1, any marker byte other than FFh marks the block bad. With STRICT_MARK=0, only the value 00h marks it bad.
- R5: lookup_bad combinationally shows 1 when block lookup_blk was found bad in the latest scan. The whole bitmap is cleared when a scan starts.
- R6: bad_count equals the number of bad markers seen since the latest start. It never steps by more than one per cycle.
- R7: overflow becomes 1 when bad_count exceeds MAX_BAD and stays 1 until the next start. Scanning continues to the last block regardless.
- R8: busy is high from the cycle after an accepted start until the last marker byte is taken. done is high from the edge that takes the last byte until the next start. A start pulse while busy is ignored.
- R9: A start accepted while done restarts the walk from block 0 and clears bad_count, overflow and the bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan (accepted when idle or done) |
| cmd_valid | output | 1 | Page-read request to the sequencer is valid |
| cmd_ready | input | 1 | Sequencer accepts the request |
| cmd_row | output | ROW_W | Row address (block·pages, page 0) |
| cmd_col | output | COL_W | Column address of the marker byte |
| rd_valid | input | 1 | Marker byte from the sequencer is valid |
| rd_byte | input | 8 | Marker byte |
| lookup_blk | input | BLK_W | Block number to query in the bitmap |
| lookup_bad | output | 1 | Queried block is flagged bad |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan complete |
| bad_count | output | CNT_W | Number of bad blocks found |
| overflow | output | 1 | Bad-block count exceeded MAX_BAD |

## Verification
If the block index is wrong, cmd_row shows it on the very next request. A corrupted bitmap bit or tally shows up at lookup_bad and bad_count at the latest when the scan finishes. A control state that accepts stray bytes or drops a request shows up as a wrong verdict on the affected block, or as a request that repeats or skips a row. The bench runs a small array through all-good, all-bad and mixed marker patterns. It includes tallies exactly at the allowance and one past it, and it runs strict and lenient instances side by side so that every verdict is checked for every block.

// File: rtl/bbscan_pkg.sv
package bbscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } scan_state_e;

  // Marker verdict: strict flags anything not erased, lenient only 00h.
  function automatic logic marker_is_bad(input logic [7:0] v, input bit strict);
    if (strict) return (v != 8'hFF);
    return (v == 8'h00);
  endfunction

endpackage

// File: rtl/bbscan_ctrl.sv
module bbscan_ctrl
  import bbscan_pkg::*;
#(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MARKER_COL      = 2048,
  parameter int COL_W           = 12,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int PAGE_W = $clog2(PAGES_PER_BLOCK),
  localparam int ROW_W  = BLK_W + PAGE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmd_ready,
  input  logic             rd_valid,
  output logic             cmd_valid,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             busy,
  output logic             done,
  output logic             clear,
  output logic             fire,
  output logic [BLK_W-1:0] probe_blk
);

  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  scan_state_e      state_q, state_d;
  logic [BLK_W-1:0] blk_q, blk_d;

  always_comb begin
    state_d = state_q;
    blk_d   = blk_q;
    clear   = 1'b0;
    fire    = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          clear   = 1'b1;
          blk_d   = '0;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (cmd_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rd_valid) begin
          fire = 1'b1;
          if (blk_q == LAST_BLK) begin
            state_d = ST_DONE;
          end else begin
            blk_d   = blk_q + 1'b1;
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
    end else begin
      state_q <= state_d;
      blk_q   <= blk_d;
    end
  end

  assign cmd_valid = (state_q == ST_ISSUE);
  assign cmd_row   = ROW_W'(blk_q) << PAGE_W;
  assign cmd_col   = COL_W'(MARKER_COL);
  assign busy      = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
  assign done      = (state_q == ST_DONE);
  assign probe_blk = blk_q;

  // R2: a pending request is held with a stable row
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_row)));

  // R3: nothing new is requested while a byte is outstanding
  a_r3_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

endmodule

// File: rtl/bbscan_bitmap.sv
module bbscan_bitmap #(
  parameter int NUM_BLOCKS = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_idx,
  input  logic [BLK_W-1:0] rd_idx,
  output logic             rd_bit
);

  logic [NUM_BLOCKS-1:0] map_q, map_d;

  always_comb begin
    map_d = map_q;
    if (clear)       map_d = '0;
    else if (set_en) map_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                map_q <= '0;
    else if (clear || set_en)  map_q <= map_d;
  end

  assign rd_bit = map_q[rd_idx];

  // R5: a clear empties the table on the next cycle
  a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (map_q == '0));

endmodule

// File: rtl/bbscan_tally.sv
module bbscan_tally #(
  parameter int NUM_BLOCKS = 2048,
  parameter int MAX_BAD    = 40,
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BAD);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clear) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LIMIT) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clear || inc) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign count    = cnt_q;
  assign overflow = ovf_q;

  // R6: the tally moves by at most one, or returns to zero on clear
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // R7: overflow only while above the allowance, and sticky until clear
  a_r7_overflow_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q > LIMIT));
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clear) |=> ovf_q);

endmodule

// File: rtl/badblk_scanner.sv
module badblk_scanner
  import bbscan_pkg::*;
#(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int DATA_BYTES      = 2048,
  parameter int SPARE_BYTES     = 64,
  parameter int MAX_BAD         = 40,
  parameter bit STRICT_MARK     = 1'b1,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = BLK_W + $clog2(PAGES_PER_BLOCK),
  localparam int COL_W = $clog2(DATA_BYTES + SPARE_BYTES),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  input  logic             rd_valid,
  input  logic [7:0]       rd_byte,
  input  logic [BLK_W-1:0] lookup_blk,
  output logic             lookup_bad,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] bad_count,
  output logic             overflow
);

  logic             clear, fire, is_bad;
  logic [BLK_W-1:0] probe_blk;

  bbscan_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .MARKER_COL(DATA_BYTES), .COL_W(COL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_ready(cmd_ready),
    .rd_valid(rd_valid), .cmd_valid(cmd_valid), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .busy(busy), .done(done), .clear(clear),
    .fire(fire), .probe_blk(probe_blk)
  );

  assign is_bad = marker_is_bad(rd_byte, STRICT_MARK);

  bbscan_bitmap #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
    .clk(clk), .rst_n(rst_n), .clear(clear), .set_en(fire && is_bad),
    .set_idx(probe_blk), .rd_idx(lookup_blk), .rd_bit(lookup_bad)
  );

  bbscan_tally #(.NUM_BLOCKS(NUM_BLOCKS), .MAX_BAD(MAX_BAD)) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(clear), .inc(fire && is_bad),
    .count(bad_count), .overflow(overflow)
  );

  // R8: a finished engine issues nothing and is not busy
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmd_valid && !busy));

  // R9: an accepted start leads to a fresh request with zeroed results
  a_r9_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (cmd_valid && bad_count == '0 && !overflow));

endmodule

// File: tb/test_badblk_scanner.sv
module test_badblk_scanner;

  localparam int NB = 16, PPB = 4, DB = 32, SB = 8, MB = 3;
  localparam int BLK_W = $clog2(NB);
  localparam int ROW_W = BLK_W + $clog2(PPB);
  localparam int COL_W = $clog2(DB + SB);
  localparam int CNT_W = $clog2(NB + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmd_ready = 1'b0;
  logic rd_valid = 1'b0;
  logic [7:0] rd_byte = 8'hFF;
  logic [BLK_W-1:0] lookup_blk = '0;
  logic cv0, cv1, lb0, lb1, busy0, busy1, done0, done1, ovf0, ovf1;
  logic [ROW_W-1:0] row0, row1;
  logic [COL_W-1:0] col0, col1;
  logic [CNT_W-1:0] cnt0, cnt1;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  badblk_scanner #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .DATA_BYTES(DB),
    .SPARE_BYTES(SB), .MAX_BAD(MB), .STRICT_MARK(1'b1)) i_badblk_scanner (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cv0),
    .cmd_ready(cmd_ready), .cmd_row(row0), .cmd_col(col0),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .lookup_blk(lookup_blk),
    .lookup_bad(lb0), .busy(busy0), .done(done0), .bad_count(cnt0),
    .overflow(ovf0));

  badblk_scanner #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .DATA_BYTES(DB),
    .SPARE_BYTES(SB), .MAX_BAD(MB), .STRICT_MARK(1'b0)) i_lenient (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cv1),
    .cmd_ready(cmd_ready), .cmd_row(row1), .cmd_col(col1),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .lookup_blk(lookup_blk),
    .lookup_bad(lb1), .busy(busy1), .done(done1), .bad_count(cnt1),
    .overflow(ovf1));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] marker(input int run, input int b);
    case (run)
      0: return 8'hFF;
      1: case (b % 8)
           1: return 8'h00;
           2: return 8'h5A;
           5: return 8'hFE;
           default: return 8'hFF;
         endcase
      2: return 8'h00;
      3: return (b == 0 || b == 7 || b == 15) ? 8'h00 : 8'hFF;
      default: return (b == 0 || b == 7 || b == 8 || b == 15) ? 8'h00 : 8'hFF;
    endcase
  endfunction

  task automatic run_scan(input int run);
    int exp_s = 0, exp_l = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy0 && busy1, "R8", "busy after start", busy0, 1);
    check(cnt0 == 0 && !ovf0, "R9", "tally cleared at start", cnt0, 0);
    for (int b = 0; b < NB; b++) begin
      int guard = 0;
      while (!cv0 && guard < 50) begin @(negedge clk); guard++; end
      check(row0 == ROW_W'(b * PPB), "R2", "request row", row0, b * PPB);
      check(col0 == COL_W'(DB), "R2", "request column", col0, DB);
      check(row1 == row0 && cv1 == cv0, "R2", "lenient row", row1, row0);
      for (int i = 0; i < b % 3; i++) begin
        rd_valid = (i == 0); rd_byte = 8'h00;  // stray byte, R3
        @(negedge clk);
      end
      rd_valid = 1'b0;
      check(cv0 == 1'b1, "R2", "request held", cv0, 1);
      if (run == 1 && b == 5) start = 1'b1;  // ignored while busy, R8
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0; start = 1'b0;
      for (int i = 0; i < b % 2; i++) begin
        check(cv0 == 1'b0, "R3", "no request while waiting", cv0, 0);
        @(negedge clk);
      end
      check(cv0 == 1'b0, "R3", "no request before byte", cv0, 0);
      rd_valid = 1'b1; rd_byte = marker(run, b);
      if (marker(run, b) != 8'hFF) exp_s++;
      if (marker(run, b) == 8'h00) exp_l++;
      @(negedge clk);
      rd_valid = 1'b0; rd_byte = 8'hFF;
    end
    check(done0 && done1 && !busy0 && !busy1, "R8", "done after last", done0, 1);
    check(cnt0 == CNT_W'(exp_s), "R6", "strict count", cnt0, exp_s);
    check(cnt1 == CNT_W'(exp_l), "R6", "lenient count", cnt1, exp_l);
    check(ovf0 == (exp_s > MB), "R7", "strict overflow", ovf0, int'(exp_s > MB));
    check(ovf1 == (exp_l > MB), "R7", "lenient overflow", ovf1, int'(exp_l > MB));
    for (int b = 0; b < NB; b++) begin
      lookup_blk = BLK_W'(b);
      #1;
      check(lb0 == (marker(run, b) != 8'hFF), "R4", "strict verdict", lb0,
            int'(marker(run, b) != 8'hFF));
      check(lb1 == (marker(run, b) == 8'h00), "R5", "lenient bitmap", lb1,
            int'(marker(run, b) == 8'h00));
    end
    repeat (3) @(negedge clk);
    check(done0 && !cv0, "R8", "done holds", done0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!cv0 && !busy0 && !done0 && !ovf0 && cnt0 == 0, "R1",
          "reset state", cnt0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cv0 && !done0 && !busy0, "R1", "idle after release", cv0, 0);
    run_scan(1);
    run_scan(2);
    run_scan(0);  // R5/R9: bitmap fully cleared after all-bad run
    run_scan(3);  // R7 boundary: exactly the allowance
    run_scan(4);  // R7 boundary: one past the allowance
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule